// File: doc/BRIEF.md
# Serial 1101 Pattern Recognizer

This block watches a one-bit serial stream and raises a flag in the same cycle that the last bit of the pattern 1, 1, 0, 1 arrives. It samples the stream on every rising clock edge. The flag is a Mealy output, so it depends on both the current state and the live input bit.

Matches may overlap. The closing 1 of a match also counts as the first 1 of the next candidate. The stream 1101101 therefore gives two detections. The machine has four states: idle, one 1 seen, two 1s seen, and 1,1,0 seen.

Reset is asserted asynchronously by an active-low pin. Its release is retimed through a short synchronizer chain. The machine begins to sample the stream on the first clock edge after the chain has released.

Top module: `seq1101_detector`

## Requirements
- R1: While `rst_n` is low, `det_o` is 0 for any value on `bit_i`. After release the machine starts in the idle state with no bit history.
- R2: `det_o` is 1 exactly when the three most recent sampled bits, oldest first, are 1, 1, 0 and the bit now present on `bit_i` is 1. All other times it is 0.
- R3: `det_o` follows `bit_i` within the same cycle. No register lies between `bit_i` and `det_o`, so a 0 on `bit_i` always leaves `det_o` at 0.
- R4: The 1 that completes a match counts as the first 1 of the next match. The input 1101101 gives `det_o` = 1 on the 4th bit and on the 7th bit.
- R5: Any run of three or more 1s followed by 0 and then 1 is a match, because extra 1s keep the two-1s history. The input 11101 gives `det_o` = 1 on the 5th bit.
- R6: A 0 that arrives after 1,1,0 clears the history. The input 11001 gives no detection.
- R7: Bits sampled before a reset never contribute to a match after it. Sampling 1,1,0, then resetting, then presenting 1 gives `det_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release retimed inside |
| bit_i | input | 1 | Serial data bit, sampled on each rising edge |
| det_o | output | 1 | Mealy flag, high on the bit that completes 1101 |

## Verification
The bench looks for cycles in which the end of one match and the start of the next fall on the same bit. In those cycles the completing 1 must raise `det_o` and must also be kept as the first 1 of the next match. The bench provokes this with directed 1101101 and 1101101101 streams. It also uses random streams biased toward 1s, where long chains of overlapping matches are common. Each bit is compared against a reference that tracks only the last three sampled bits, so a correct flag in the overlap cycle alone is not enough. The flag three bits later must also match.

// File: rtl/seq1101_pkg.sv
`timescale 1ns/1ps
package seq1101_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_GOT1  = 2'd1,
    ST_GOT11 = 2'd2,
    ST_GOT110 = 2'd3
  } det_state_e;
endpackage

// File: rtl/seq1101_rst_sync.sv
`timescale 1ns/1ps
module seq1101_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/seq1101_next_logic.sv
`timescale 1ns/1ps
module seq1101_next_logic
  import seq1101_pkg::*;
(
  input  det_state_e cur_st,
  input  logic       bit_i,
  output det_state_e nxt_st,
  output logic       hit
);
  always_comb begin
    nxt_st = ST_IDLE;
    hit    = 1'b0;
    unique case (cur_st)
      ST_IDLE:   nxt_st = bit_i ? ST_GOT1  : ST_IDLE;
      ST_GOT1:   nxt_st = bit_i ? ST_GOT11 : ST_IDLE;
      ST_GOT11:  nxt_st = bit_i ? ST_GOT11 : ST_GOT110;
      ST_GOT110: begin
        nxt_st = bit_i ? ST_GOT1 : ST_IDLE;
        hit    = bit_i;
      end
      default:   nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seq1101_state_reg.sv
`timescale 1ns/1ps
module seq1101_state_reg
  import seq1101_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic       upd_en,
  input  det_state_e nxt_st,
  output det_state_e cur_st
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cur_st <= ST_IDLE;
    else if (upd_en)  cur_st <= nxt_st;
  end
endmodule

// File: rtl/seq1101_detector.sv
`timescale 1ns/1ps
module seq1101_detector
  import seq1101_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic det_o
);
  logic       rst_sync_n;
  det_state_e cur_st;
  det_state_e nxt_st;
  logic       hit;
  logic       upd_en;

  assign upd_en = 1'b1;

  seq1101_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq1101_next_logic u_next (
    .cur_st (cur_st),
    .bit_i  (bit_i),
    .nxt_st (nxt_st),
    .hit    (hit)
  );

  seq1101_state_reg u_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .upd_en     (upd_en),
    .nxt_st     (nxt_st),
    .cur_st     (cur_st)
  );

  assign det_o = hit;

  // R1
  idle_in_reset_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (cur_st == ST_IDLE && !det_o));

  // R3
  det_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    det_o |-> bit_i);

  // R2
  det_needs_110_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    det_o |-> (!$past(bit_i, 1) && $past(bit_i, 2) && $past(bit_i, 3)));

  // R4
  overlap_keeps_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    det_o |=> (cur_st == ST_GOT1));

  // R5
  ones_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_st == ST_GOT11 && bit_i) |=> (cur_st == ST_GOT11));

  // R6
  zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_st == ST_GOT110 && !bit_i) |=> (cur_st == ST_IDLE));
endmodule

// File: tb/seq1101_detector_test.sv
`timescale 1ns/1ps
module seq1101_detector_test;
  localparam int RST_STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_i = 1'b0;
  logic det_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] hist = '0;
  int hist_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seq1101_detector #(.RST_STAGES(RST_STAGES)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_i (bit_i),
    .det_o (det_o)
  );

  function automatic logic model_det(logic [2:0] h, int cnt, logic b);
    return (cnt >= 3) && (h == 3'b110) && b;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: det_o=%b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(logic b, string req);
    @(negedge clk);
    bit_i = b;
    #1;
    check(req, det_o, model_det(hist, hist_cnt, b));
    @(posedge clk);
    hist = {hist[1:0], b};
    hist_cnt++;
  endtask

  task automatic send_seq(logic [15:0] bits, int n, string req);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i], req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check("R1", det_o, 1'b0);
    end
    bit_i = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < RST_STAGES + 1; i++) @(posedge clk);
    hist = '0;
    hist_cnt = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1", det_o, 1'b0);
    do_reset();

    // R2: basic match
    send_seq(16'b1101, 4, "R2");
    // R4: overlapping matches
    do_reset();
    send_seq(16'b1101101, 7, "R4");
    send_seq(16'b101101, 6, "R4");
    // R5: long run of ones
    do_reset();
    send_seq(16'b1111101, 7, "R5");
    // R6: zero after 110 clears
    do_reset();
    send_seq(16'b11001, 5, "R6");
    // R3: zero on bit never flags
    do_reset();
    send_seq(16'b1100, 4, "R3");
    // R7: history forgotten across reset
    do_reset();
    send_seq(16'b110, 3, "R7");
    do_reset();
    send_bit(1'b1, "R7");

    // R2/R3: random streams biased toward ones
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic b;
      b = (($urandom % 4) != 0);
      if (i >= 1500) b = $urandom % 2;
      send_bit(b, "R2");
      if (i == 1000) do_reset();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule